// File: doc/BRIEF.md
# Indexed Codec Control Register File

This block is the byte-wide host-side control front end of an audio codec. The host reaches it through three direct locations: an index register, a data window and a status register. The index selects one register in a bank of indirect control registers, and the data window reads or writes that register. Each indirect register has its own reset value and its own write rule. The block also models three things: the mode-change gating on the sample-format byte, a calibration busy countdown that software can poll, and the interrupt status that the host acknowledges.

The rest of the codec reads the current format byte and the playback enable from it, and sees a level interrupt request. The datapath reports the end of a playback block as a single-cycle event pulse. Host accesses are single-cycle strobes. Read data comes back as a stream with a valid flag one cycle after the strobe. This return stream has no ready signal and no back-pressure, so the host must take the byte in the cycle in which the valid flag is high.

Top module: `codec_ctrl_regs`

## Requirements
- R1: After reset, the index register reads 0x40, the status register reads 0x00 and `irq_o` is low. `fmt_o` is 0x00 and `play_en_o` is 0.
- R2: The indirect registers reset to the following values; every other indirect register resets to 0x00.

  | Indirect address | Reset value |
  |---|---|
  | 2, 3, 4, 5, 18, 19 | 0x88 |
  | 6, 7 | 0x80 |
  | 9 (interface configuration) | 0x08 |
  | 12 (mode) | 0x8A |
  | 25, 26 | 0xA0 |
- R3: Writing the index register (host address 0) stores the byte with bit 7 cleared. Reading it returns the stored byte, so bit 7 always reads 0.
- R4: The indirect address depends on bit 6 of the mode register (indirect 12). It is index[3:0] when that bit is 0, and index[4:0] when it is 1.
- R5: The format register is indirect 8, driven on `fmt_o`. A data write to it is handled in one of three ways:
  - When index bit 6 (mode-change enable) is 1, the whole byte is stored.
  - Otherwise, when bit 4 of the alternate status register (indirect 24) is 1, only bits 7:4 are replaced.
  - Otherwise the write is dropped.
- R6: A write to the mode register changes only its bit 6.
- R7: Interface configuration (indirect 9) always stores bit 5 as 0, and its bit 0 drives `play_en_o`. The error/initialization register (indirect 11) ignores writes.
- R8: The calibration counter loads CAL_LEN when an index write takes bit 6 from 0 to 1 while interface configuration bits 4:3 are not both 0. While the counter is nonzero, a data-window read of indirect 11 returns bit 5 set and decrements the counter.
- R9: Any host write to the status register (host address 2) does three things:
  - It clears status bit 0, the interrupt flag.
  - It clears the playback, capture and timer flags, which are alternate status bits 1, 2 and 3.
  - It drops `irq_o`.
- R10: A data write to the alternate status register that carries bit 1 as 0, while bit 1 was 1, clears status bit 0 and drops `irq_o`. Other writes to it store the byte and never raise `irq_o`.
- R11: A `pb_event` pulse sets status bit 0, alternate status bit 1 and `irq_o`. In the same cycle it wins over either of the clearing writes of R9 and R10.
- R12: A read strobe returns its byte on `rd_data_o`, with `rd_valid_o` high, in the following cycle. Host address 3 reads 0x00 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 2 | Host location: 0 index, 1 data window, 2 status, 3 unused |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_rd | input | 1 | Single-cycle read strobe |
| bus_wdata | input | 8 | Write byte |
| rd_valid_o | output | 1 | Read return valid, one cycle after `bus_rd` |
| rd_data_o | output | 8 | Read return byte |
| pb_event | input | 1 | Playback block-done pulse from the datapath |
| fmt_o | output | 8 | Current sample-format byte |
| play_en_o | output | 1 | Playback enable |
| irq_o | output | 1 | Level interrupt request |

## Verification
In the same clock cycle, a playback-done event can coincide with a host acknowledge. The acknowledge may be a status-register write or an alternate-status write that clears the playback flag. The bench provokes this by raising `pb_event` together with the write strobe in one cycle. It then judges the outcome in two ways: `irq_o` must still be high afterwards, and the alternate status must read back with its playback flag set. Either result shows that the event was not lost.

// File: rtl/ccr_pkg.sv
package ccr_pkg;
  typedef enum logic [1:0] {
    HA_INDEX  = 2'd0,
    HA_DATA   = 2'd1,
    HA_STATUS = 2'd2,
    HA_SPARE  = 2'd3
  } host_addr_e;

  localparam int unsigned RI_FMT  = 8;
  localparam int unsigned RI_IFC  = 9;
  localparam int unsigned RI_ERR  = 11;
  localparam int unsigned RI_MODE = 12;
  localparam int unsigned RI_ALT  = 24;
  localparam int unsigned RI_VER  = 25;
  localparam int unsigned RI_MONO = 26;

  localparam int unsigned IDX_MCE_B   = 6;
  localparam int unsigned MODE_WIDE_B = 6;
  localparam int unsigned IFC_RSVD_B  = 5;
  localparam int unsigned IFC_PLAY_B  = 0;
  localparam int unsigned ERR_CAL_B   = 5;
  localparam int unsigned ALT_PI_B    = 1;
  localparam int unsigned ALT_CI_B    = 2;
  localparam int unsigned ALT_TI_B    = 3;
  localparam int unsigned ALT_PMCE_B  = 4;

  localparam logic [7:0] IDX_RESET = 8'h40;

  function automatic logic [7:0] reset_val(int unsigned a);
    case (a)
      2, 3, 4, 5, 18, 19: reset_val = 8'h88;
      6, 7:               reset_val = 8'h80;
      RI_IFC:             reset_val = 8'h08;
      RI_MODE:            reset_val = 8'h8A;
      RI_VER, RI_MONO:    reset_val = 8'hA0;
      default:            reset_val = 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] write_val(int unsigned a, logic [7:0] old,
                                           logic [7:0] wd, logic mce, logic pmce);
    logic [7:0] r;
    r = wd;
    case (a)
      RI_FMT: begin
        if (mce)       r = wd;
        else if (pmce) r = {wd[7:4], old[3:0]};
        else           r = old;
      end
      RI_IFC: begin
        r = wd;
        r[IFC_RSVD_B] = 1'b0;
      end
      RI_ERR:  r = old;
      RI_MODE: begin
        r = old;
        r[MODE_WIDE_B] = wd[MODE_WIDE_B];
      end
      default: r = wd;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/ccr_index_reg.sv
module ccr_index_reg
  import ccr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr,
  input  logic [7:0] wdata,
  output logic [7:0] idx_o,
  output logic       mce_o,
  output logic       mce_rise_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)  idx_o <= IDX_RESET;
    else if (wr) idx_o <= {1'b0, wdata[6:0]};
  end

  assign mce_o      = idx_o[IDX_MCE_B];
  assign mce_rise_o = wr && !idx_o[IDX_MCE_B] && wdata[IDX_MCE_B];
endmodule

// File: rtl/ccr_cal_counter.sv
module ccr_cal_counter #(
  parameter int unsigned CAL_LEN = 4,
  localparam int unsigned CNT_W = $clog2(CAL_LEN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             dec,
  output logic [CNT_W-1:0] cnt_o,
  output logic             busy_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)                    cnt_o <= '0;
    else if (load)                 cnt_o <= CNT_W'(CAL_LEN);
    else if (dec && cnt_o != '0)   cnt_o <= cnt_o - 1'b1;
  end

  assign busy_o = (cnt_o != '0);
endmodule

// File: rtl/ccr_int_status.sv
module ccr_int_status (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic int_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)   int_o <= 1'b0;
    else if (set) int_o <= 1'b1;
    else if (clr) int_o <= 1'b0;
  end
endmodule

// File: rtl/ccr_ind_bank.sv
module ccr_ind_bank
  import ccr_pkg::*;
#(
  parameter int unsigned ADDR_W = 5,
  localparam int unsigned DEPTH = 1 << ADDR_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [ADDR_W-1:0]     waddr,
  input  logic [7:0]            wdata,
  input  logic                  mce,
  input  logic                  stat_ack,
  input  logic                  pb_event,
  output logic [DEPTH-1:0][7:0] regs_o,
  output logic                  pi_ack_o
);
  logic pmce;
  assign pmce = regs_o[RI_ALT][ALT_PMCE_B];

  for (genvar g = 0; g < DEPTH; g++) begin : g_reg
    logic       hit;
    logic [7:0] q;
    logic [7:0] nxt;

    assign hit = wr_en && (waddr == ADDR_W'(g));

    always_comb begin
      nxt = hit ? write_val(g, q, wdata, mce, pmce) : q;
      if (g == RI_ALT) begin
        if (stat_ack) begin
          nxt[ALT_PI_B] = 1'b0;
          nxt[ALT_CI_B] = 1'b0;
          nxt[ALT_TI_B] = 1'b0;
        end
        if (pb_event) nxt[ALT_PI_B] = 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n) q <= reset_val(g);
      else        q <= nxt;
    end

    assign regs_o[g] = q;
  end

  assign pi_ack_o = wr_en && (waddr == ADDR_W'(RI_ALT)) &&
                    regs_o[RI_ALT][ALT_PI_B] && !wdata[ALT_PI_B];
endmodule

// File: rtl/codec_ctrl_regs.sv
module codec_ctrl_regs
  import ccr_pkg::*;
#(
  parameter int unsigned IDX_W   = 5,
  parameter int unsigned CAL_LEN = 4,
  localparam int unsigned DEPTH  = 1 << IDX_W,
  localparam int unsigned CNT_W  = $clog2(CAL_LEN + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] bus_addr,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic [7:0] bus_wdata,
  output logic       rd_valid_o,
  output logic [7:0] rd_data_o,
  input  logic       pb_event,
  output logic [7:0] fmt_o,
  output logic       play_en_o,
  output logic       irq_o
);
  host_addr_e ha;
  assign ha = host_addr_e'(bus_addr);

  logic idx_wr, data_wr, stat_ack;
  assign idx_wr   = bus_wr && (ha == HA_INDEX);
  assign data_wr  = bus_wr && (ha == HA_DATA);
  assign stat_ack = bus_wr && (ha == HA_STATUS);

  logic [7:0] idx;
  logic       mce, mce_rise;

  ccr_index_reg u_idx (
    .clk(clk), .rst_n(rst_n), .wr(idx_wr), .wdata(bus_wdata),
    .idx_o(idx), .mce_o(mce), .mce_rise_o(mce_rise)
  );

  logic [DEPTH-1:0][7:0] regs;
  logic                  pi_ack;
  logic                  wide;
  logic [IDX_W-1:0]      iaddr;

  assign wide  = regs[RI_MODE][MODE_WIDE_B];
  assign iaddr = wide ? idx[IDX_W-1:0] : {1'b0, idx[IDX_W-2:0]};

  ccr_ind_bank #(.ADDR_W(IDX_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(data_wr), .waddr(iaddr),
    .wdata(bus_wdata), .mce(mce), .stat_ack(stat_ack), .pb_event(pb_event),
    .regs_o(regs), .pi_ack_o(pi_ack)
  );

  logic [7:0] alt_q, ifc_q;
  logic       pmce;
  assign alt_q = regs[RI_ALT];
  assign ifc_q = regs[RI_IFC];
  assign pmce  = alt_q[ALT_PMCE_B];

  logic             cal_load, cal_dec, cal_busy, err_hit;
  logic [CNT_W-1:0] cal_cnt;
  assign err_hit  = (iaddr == IDX_W'(RI_ERR));
  assign cal_load = mce_rise && (ifc_q[4:3] != 2'b00);
  assign cal_dec  = bus_rd && (ha == HA_DATA) && err_hit && cal_busy;

  ccr_cal_counter #(.CAL_LEN(CAL_LEN)) u_cal (
    .clk(clk), .rst_n(rst_n), .load(cal_load), .dec(cal_dec),
    .cnt_o(cal_cnt), .busy_o(cal_busy)
  );

  logic stat_int;
  ccr_int_status u_int (
    .clk(clk), .rst_n(rst_n), .set(pb_event), .clr(stat_ack || pi_ack),
    .int_o(stat_int)
  );

  logic [7:0] rd_mux;
  always_comb begin
    rd_mux = 8'h00;
    case (ha)
      HA_INDEX:  rd_mux = {1'b0, idx[6:0]};
      HA_DATA: begin
        rd_mux = regs[iaddr];
        if (err_hit && cal_busy) rd_mux[ERR_CAL_B] = 1'b1;
      end
      HA_STATUS: rd_mux = {7'b0, stat_int};
      default:   rd_mux = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid_o <= 1'b0;
      rd_data_o  <= 8'h00;
    end else begin
      rd_valid_o <= bus_rd;
      if (bus_rd) rd_data_o <= rd_mux;
    end
  end

  assign fmt_o     = regs[RI_FMT];
  assign play_en_o = ifc_q[IFC_PLAY_B];
  assign irq_o     = stat_int;
endmodule

// File: rtl/ccr_checker.sv
module ccr_checker
  import ccr_pkg::*;
#(
  parameter int unsigned IDX_W   = 5,
  parameter int unsigned CAL_LEN = 4,
  localparam int unsigned CNT_W  = $clog2(CAL_LEN + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       bus_addr,
  input logic             bus_wr,
  input logic             bus_rd,
  input logic [7:0]       bus_wdata,
  input logic [7:0]       rd_data_o,
  input logic             pb_event,
  input logic [7:0]       fmt_o,
  input logic             irq_o,
  input logic [IDX_W-1:0] iaddr,
  input logic             mce,
  input logic             pmce,
  input logic [CNT_W-1:0] cal_cnt,
  input logic [7:0]       alt_q,
  input logic [7:0]       ifc_q
);
  a_r3_idx_bit7_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == 2'd0) |=> (rd_data_o[7] == 1'b0));

  a_r5_fmt_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 2'd1 && iaddr == IDX_W'(RI_FMT) && !mce && !pmce)
      |=> $stable(fmt_o));

  a_r7_ifc_rsvd_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ifc_q[IFC_RSVD_B] == 1'b0);

  a_r8_cal_dec: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_cnt != '0 && bus_rd && bus_addr == 2'd1 && iaddr == IDX_W'(RI_ERR) &&
     !(bus_wr && bus_addr == 2'd0))
      |=> (cal_cnt == $past(cal_cnt) - 1'b1));

  a_r9_ack_drops_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 2'd2 && !pb_event) |=> !irq_o);

  a_r10_pi_clear_drops_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 2'd1 && iaddr == IDX_W'(RI_ALT) && alt_q[ALT_PI_B] &&
     !bus_wdata[ALT_PI_B] && !pb_event) |=> !irq_o);

  a_r11_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
    pb_event |=> (irq_o && alt_q[ALT_PI_B]));
endmodule

bind codec_ctrl_regs ccr_checker #(.IDX_W(IDX_W), .CAL_LEN(CAL_LEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_rd(bus_rd), .bus_wdata(bus_wdata), .rd_data_o(rd_data_o),
  .pb_event(pb_event), .fmt_o(fmt_o), .irq_o(irq_o), .iaddr(iaddr),
  .mce(mce), .pmce(pmce), .cal_cnt(cal_cnt), .alt_q(alt_q), .ifc_q(ifc_q)
);

// File: tb/tb_codec_ctrl_regs.sv
`timescale 1ns/1ps
module tb_codec_ctrl_regs;
  localparam int unsigned CAL_LEN = 4;
  localparam logic [1:0] A_IDX = 2'd0, A_DAT = 2'd1, A_STA = 2'd2, A_SPR = 2'd3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0, pb_event = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic       rd_valid_o, play_en_o, irq_o;
  logic [7:0] rd_data_o, fmt_o;

  int total = 0, bad = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #5 clk = ~clk;

  codec_ctrl_regs #(.IDX_W(5), .CAL_LEN(CAL_LEN)) dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .rd_valid_o(rd_valid_o),
    .rd_data_o(rd_data_o), .pb_event(pb_event), .fmt_o(fmt_o),
    .play_en_o(play_en_o), .irq_o(irq_o)
  );

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic wr_ev(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1; pb_event = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; pb_event = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, logic [7:0] exp, string tag);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic pulse_event();
    @(negedge clk); pb_event = 1'b1;
    @(negedge clk); pb_event = 1'b0;
  endtask

  // monitor: read returns are compared against the scoreboard queue
  initial begin
    forever begin
      @(negedge clk);
      if (rd_valid_o) begin
        if (exp_q.size() == 0) begin
          total++; bad++;
          $display("FAIL R12 unexpected read return actual=%02h expected=none", rd_data_o);
        end else begin
          check(tag_q.pop_front(), rd_data_o, exp_q.pop_front());
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 irq", {7'b0, irq_o}, 8'h00);
    check("R1 fmt", fmt_o, 8'h00);
    check("R1 play_en", {7'b0, play_en_o}, 8'h00);
    rd(A_IDX, 8'h40, "R1 index");
    rd(A_STA, 8'h00, "R1 status");
    wr(A_SPR, 8'hFF);
    rd(A_SPR, 8'h00, "R12 spare");
    // R2 reset values
    wr(A_IDX, 8'h42); rd(A_DAT, 8'h88, "R2 aux");
    wr(A_IDX, 8'h47); rd(A_DAT, 8'h80, "R2 dac");
    wr(A_IDX, 8'h49); rd(A_DAT, 8'h08, "R2 ifc");
    wr(A_IDX, 8'h4C); rd(A_DAT, 8'h8A, "R2 mode");
    wr(A_IDX, 8'h41); rd(A_DAT, 8'h00, "R2 other");
    // R3 index bit 7
    wr(A_IDX, 8'hC2); rd(A_IDX, 8'h42, "R3 index");
    // R5 format with mode-change enable
    wr(A_IDX, 8'h48); wr(A_DAT, 8'h5B);
    check("R5 full write", fmt_o, 8'h5B);
    rd(A_DAT, 8'h5B, "R5 readback");
    wr(A_IDX, 8'h08); wr(A_DAT, 8'h37);
    check("R5 dropped", fmt_o, 8'h5B);
    // R6 mode register
    wr(A_IDX, 8'h0C); wr(A_DAT, 8'h3F);
    rd(A_DAT, 8'h8A, "R6 other bits kept");
    wr(A_DAT, 8'h40);
    rd(A_DAT, 8'hCA, "R6 bit6 set");
    // R4 wide addressing
    wr(A_IDX, 8'h19); rd(A_DAT, 8'hA0, "R4 wide addr 25");
    // R5 nibble merge via alternate status bit 4
    wr(A_IDX, 8'h18); wr(A_DAT, 8'h10);
    wr(A_IDX, 8'h08); wr(A_DAT, 8'hE4);
    check("R5 merge", fmt_o, 8'hEB);
    // R4 back to narrow
    wr(A_IDX, 8'h0C); wr(A_DAT, 8'h00);
    wr(A_IDX, 8'h19); rd(A_DAT, 8'h08, "R4 narrow addr 9");
    // R7 interface config and error register
    wr(A_DAT, 8'hFF); rd(A_DAT, 8'hDF, "R7 ifc bit5");
    check("R7 play_en", {7'b0, play_en_o}, 8'h01);
    wr(A_IDX, 8'h1B); wr(A_DAT, 8'hFF);
    rd(A_DAT, 8'h00, "R7 err ignores write");
    // R8 calibration countdown
    wr(A_IDX, 8'h4B);
    for (int i = 0; i < CAL_LEN; i++) rd(A_DAT, 8'h20, "R8 busy");
    rd(A_DAT, 8'h00, "R8 done");
    wr(A_IDX, 8'h4B); rd(A_DAT, 8'h00, "R8 no rise");
    wr(A_IDX, 8'h49); wr(A_DAT, 8'h01);
    wr(A_IDX, 8'h0B); wr(A_IDX, 8'h4B);
    rd(A_DAT, 8'h00, "R8 ifc gate");
    // R11 / R9 interrupt and acknowledge
    pulse_event();
    check("R11 irq set", {7'b0, irq_o}, 8'h01);
    rd(A_STA, 8'h01, "R11 status");
    wr(A_STA, 8'h00);
    check("R9 irq clr", {7'b0, irq_o}, 8'h00);
    rd(A_STA, 8'h00, "R9 status");
    // R10 alternate status playback-flag clear
    wr(A_IDX, 8'h0C); wr(A_DAT, 8'h40);
    pulse_event();
    wr(A_IDX, 8'h18); rd(A_DAT, 8'h12, "R11 alt PI");
    wr(A_DAT, 8'h10);
    check("R10 irq clr", {7'b0, irq_o}, 8'h00);
    rd(A_STA, 8'h00, "R10 status");
    wr(A_DAT, 8'h1E);
    check("R10 no raise", {7'b0, irq_o}, 8'h00);
    pulse_event();
    wr(A_STA, 8'h00);
    check("R9 irq clr 2", {7'b0, irq_o}, 8'h00);
    rd(A_DAT, 8'h10, "R9 alt flags cleared");
    // R11 same-cycle collisions
    wr_ev(A_STA, 8'h00);
    check("R11 event vs status ack", {7'b0, irq_o}, 8'h01);
    rd(A_DAT, 8'h12, "R11 alt after collision");
    wr_ev(A_DAT, 8'h10);
    check("R11 event vs pi clear", {7'b0, irq_o}, 8'h01);
    rd(A_DAT, 8'h12, "R11 alt after pi collision");
    wr(A_STA, 8'h00);
    check("R9 final clr", {7'b0, irq_o}, 8'h00);
    repeat (4) @(negedge clk);
    check("R12 queue drained", 8'(exp_q.size()), 8'h00);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule